// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Sequencer

This block supervises the over-current and restart behaviour of a switching regulator controller. Once per switching cycle it receives a pulse together with an over-current flag sampled while the low-side switch conducts. It also watches an under-voltage flag, an over-temperature flag, a zero-cross flag and the enable input. It decides whether the high-side switch may begin a new on-time, when the low-side switch must be held off, and when the soft-start capacitor is drained or a new soft start is launched.

The valley limit works cycle by cycle: while the over-current flag is high the high side gets no permission. A sustained overload enters hiccup, and so does an output that sags below the under-voltage level. Sustained means a run of consecutive switching cycles that all carry the flag, counted only after an arming interval following each soft start. On entering hiccup the high side is removed at once. The low side stays usable until the inductor current crosses zero, and only then is it forced off. After a fixed off interval a new soft start begins on its own. Over-temperature is a separate path that does not latch: switching stops and soft start is drained until the flag clears, then a soft start follows. All millisecond intervals are clock-cycle count parameters.

Top module: `ocp_hiccup_seq`

## Requirements
- R1: `hs_permit_o` is high only while the status is SOFTSTART or RUN and, in the same cycle, `oc_valley_i` is low.
- R2: After each soft-start launch the status stays SOFTSTART for exactly ARM_CYC clock cycles, ignoring over-current and under-voltage, and then becomes RUN (absent enable loss or over-temperature).
- R3: In RUN, when `cyc_pulse_i` arrives with `oc_valley_i` high for the OC_RUN-th consecutive switching cycle, the status is HICCUP_WAIT_ZCD after the next clock edge.
- R4: A switching-cycle pulse with `oc_valley_i` low restarts the consecutive count from zero; clock cycles without `cyc_pulse_i` neither add to nor clear the count.
- R5: In RUN, `uv_i` high moves the status to HICCUP_WAIT_ZCD after the next clock edge.
- R6: In HICCUP_WAIT_ZCD the high side is not permitted and `ls_off_o` is low; the status holds until `zcd_i` is seen, then becomes HICCUP_OFF, where `ls_off_o` is high.
- R7: `ss_dis_o` is high exactly when the status is HICCUP_WAIT_ZCD, HICCUP_OFF or THERMAL_OFF.
- R8: HICCUP_OFF lasts exactly WAIT_CYC clock cycles and is followed by SOFTSTART; `ss_start_o` is high for the first cycle of every SOFTSTART entry and at no other time.
- R9: With `en_i` high, `ot_i` high moves any status to THERMAL_OFF after the next edge (high side off, `ls_off_o` high); when `ot_i` is low in THERMAL_OFF the next status is SOFTSTART.
- R10: `en_i` low (or reset) returns the status to IDLE after the next edge from any status, clearing counters; in IDLE `hs_permit_o`=0, `ls_off_o`=1, `ss_dis_o`=0. From IDLE, `en_i` high with `ot_i` low enters SOFTSTART.
- R11: `state_o` encodes IDLE=0, SOFTSTART=1, RUN=2, HICCUP_WAIT_ZCD=3, HICCUP_OFF=4, THERMAL_OFF=5; no other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| cyc_pulse_i | input | 1 | One-clock pulse per switching cycle |
| oc_valley_i | input | 1 | Valley current above limit during low-side interval |
| uv_i | input | 1 | Feedback below under-voltage level |
| ot_i | input | 1 | Junction over-temperature (hysteresis applied upstream) |
| zcd_i | input | 1 | Inductor current zero crossing |
| hs_permit_o | output | 1 | High side may start a new on-time |
| ls_off_o | output | 1 | Low side forced off |
| ss_dis_o | output | 1 | Soft-start capacitor discharge request |
| ss_start_o | output | 1 | One-cycle soft-start launch pulse |
| state_o | output | 3 | Sequencer status code |

## Verification
The assertions watch every cycle for the properties that need no history longer than one edge: the permit gate against the flag and status, the discharge decode, enable and thermal priority, the one-edge jump on under-voltage or on the counter trip, the hold while waiting for zero cross, and the launch pulse coinciding with a fresh SOFTSTART. The exact lengths of the arming and off intervals, the 31-cycle run and its reset by a clean cycle, and the insensitivity to clocks without a cycle pulse only show up in the bench's directed sequences and in its cycle-accurate reference model driven by random flags.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SOFT    = 3'd1,
    ST_RUN     = 3'd2,
    ST_HIC_ZCD = 3'd3,
    ST_HIC_OFF = 3'd4,
    ST_THERM   = 3'd5
  } seq_state_t;

  // Width of a counter that must hold values 0..limit
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // High side may be granted in these states
  function automatic logic hs_window(input seq_state_t st);
    return (st == ST_SOFT) || (st == ST_RUN);
  endfunction

  // Low side held off in these states
  function automatic logic ls_blocked(input seq_state_t st);
    return (st == ST_IDLE) || (st == ST_HIC_OFF) || (st == ST_THERM);
  endfunction

  // Soft-start capacitor drained in these states
  function automatic logic ss_drain(input seq_state_t st);
    return (st == ST_HIC_ZCD) || (st == ST_HIC_OFF) || (st == ST_THERM);
  endfunction

endpackage

// File: rtl/ocp_dwell_timer.sv
module ocp_dwell_timer #(
  parameter int LIMIT = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = ocp_hiccup_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/ocp_run_counter.sv
module ocp_run_counter #(
  parameter int LIMIT = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic pulse,
  input  logic flag,
  output logic trip
);
  localparam int W = ocp_hiccup_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;
  logic         hit;

  assign hit  = armed && pulse && flag;
  assign trip = hit && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!armed) cnt <= '0;
    else if (pulse) begin
      if (!flag)          cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
  import ocp_hiccup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ot,
  input  logic       uv,
  input  logic       zcd,
  input  logic       arm_done,
  input  logic       wait_done,
  input  logic       oc_trip,
  output seq_state_t cur,
  output logic       launch
);
  seq_state_t nxt;

  always_comb begin
    nxt = cur;
    if (!en)      nxt = ST_IDLE;
    else if (ot)  nxt = ST_THERM;
    else begin
      unique case (cur)
        ST_IDLE:    nxt = ST_SOFT;
        ST_SOFT:    if (arm_done) nxt = ST_RUN;
        ST_RUN:     if (uv || oc_trip) nxt = ST_HIC_ZCD;
        ST_HIC_ZCD: if (zcd) nxt = ST_HIC_OFF;
        ST_HIC_OFF: if (wait_done) nxt = ST_SOFT;
        ST_THERM:   nxt = ST_SOFT;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= ST_IDLE;
      launch <= 1'b0;
    end else begin
      cur    <= nxt;
      launch <= (nxt == ST_SOFT) && (cur != ST_SOFT);
    end
  end
endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq
  import ocp_hiccup_pkg::*;
#(
  parameter int ARM_CYC  = 300000,
  parameter int WAIT_CYC = 1100000,
  parameter int OC_RUN   = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       cyc_pulse_i,
  input  logic       oc_valley_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       zcd_i,
  output logic       hs_permit_o,
  output logic       ls_off_o,
  output logic       ss_dis_o,
  output logic       ss_start_o,
  output logic [2:0] state_o
);
  seq_state_t st;
  logic       in_soft, in_run, in_off;
  logic       arm_done, wait_done, oc_trip, launch;

  assign in_soft = (st == ST_SOFT);
  assign in_run  = (st == ST_RUN);
  assign in_off  = (st == ST_HIC_OFF);

  ocp_dwell_timer #(.LIMIT(ARM_CYC)) i_arm_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_soft), .done(arm_done)
  );

  ocp_dwell_timer #(.LIMIT(WAIT_CYC)) i_wait_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_off), .done(wait_done)
  );

  ocp_run_counter #(.LIMIT(OC_RUN)) i_oc_cnt (
    .clk(clk), .rst_n(rst_n), .armed(in_run),
    .pulse(cyc_pulse_i), .flag(oc_valley_i), .trip(oc_trip)
  );

  ocp_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .en(en_i), .ot(ot_i), .uv(uv_i),
    .zcd(zcd_i), .arm_done(arm_done), .wait_done(wait_done),
    .oc_trip(oc_trip), .cur(st), .launch(launch)
  );

  assign hs_permit_o = hs_window(st) && !oc_valley_i;
  assign ls_off_o    = ls_blocked(st);
  assign ss_dis_o    = ss_drain(st);
  assign ss_start_o  = launch;
  assign state_o     = st;
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       oc_valley_i,
  input logic       uv_i,
  input logic       ot_i,
  input logic       zcd_i,
  input logic       hs_permit_o,
  input logic       ls_off_o,
  input logic       ss_dis_o,
  input logic       ss_start_o,
  input logic [2:0] state_o,
  input logic       oc_trip
);
  // R1
  hs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_permit_o |-> (!oc_valley_i && (state_o == 3'd1 || state_o == 3'd2)));

  // R2
  soft_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && en_i && !ot_i) |=> (state_o == 3'd1 || state_o == 3'd2));

  // R3
  run_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip && en_i && !ot_i) |=> (state_o == 3'd3));

  // R5
  uv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && uv_i && en_i && !ot_i) |=> (state_o == 3'd3));

  // R6
  zcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && !zcd_i && en_i && !ot_i) |=> (state_o == 3'd3 && !ls_off_o && !hs_permit_o));

  // R7
  drain_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_dis_o == (state_o == 3'd3 || state_o == 3'd4 || state_o == 3'd5));

  // R8
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start_o |-> (state_o == 3'd1 && $past(state_o) != 3'd1));

  // R9
  thermal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ot_i) |=> (state_o == 3'd5 && ls_off_o));

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_o == 3'd0 && ls_off_o && !ss_dis_o));

  // R11
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);
endmodule

bind ocp_hiccup_seq ocp_hiccup_chk i_ocp_hiccup_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .oc_valley_i(oc_valley_i),
  .uv_i(uv_i), .ot_i(ot_i), .zcd_i(zcd_i), .hs_permit_o(hs_permit_o),
  .ls_off_o(ls_off_o), .ss_dis_o(ss_dis_o), .ss_start_o(ss_start_o),
  .state_o(state_o), .oc_trip(oc_trip)
);

// File: tb/test_ocp_hiccup_seq.sv
`timescale 1ns/1ps
module test_ocp_hiccup_seq;
  localparam int ARM = 20;
  localparam int WT  = 15;
  localparam int RUNL = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, cyc = 0, oc = 0, uv = 0, ot = 0, zcd = 0;
  logic hs, lso, ssd, sss;
  logic [2:0] st;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  ocp_hiccup_seq #(.ARM_CYC(ARM), .WAIT_CYC(WT), .OC_RUN(RUNL)) i_ocp_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .cyc_pulse_i(cyc), .oc_valley_i(oc),
    .uv_i(uv), .ot_i(ot), .zcd_i(zcd), .hs_permit_o(hs), .ls_off_o(lso),
    .ss_dis_o(ssd), .ss_start_o(sss), .state_o(st));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: status codes 0 idle,1 soft,2 run,3 wait-zcd,4 off,5 thermal
  int m_st = 0, m_dw = 0, m_run = 0;
  bit m_go = 0;

  function automatic bit exp_hs(int s, bit f);  return (s == 1 || s == 2) && !f; endfunction
  function automatic bit exp_lso(int s);        return s == 0 || s == 4 || s == 5; endfunction
  function automatic bit exp_ssd(int s);        return s >= 3; endfunction

  always @(posedge clk or negedge rst_n) begin
    int n;
    if (!rst_n) begin
      m_st <= 0; m_dw <= 0; m_run <= 0; m_go <= 0;
    end else begin
      n = m_st;
      if (!en) n = 0;
      else if (ot) n = 5;
      else case (m_st)
        0: n = 1;
        1: if (m_dw + 1 >= ARM) n = 2;
        2: if (uv || (cyc && oc && m_run + 1 >= RUNL)) n = 3;
        3: if (zcd) n = 4;
        4: if (m_dw + 1 >= WT) n = 5 - 4;
        default: n = 1;
      endcase
      m_dw  <= (n == m_st) ? m_dw + 1 : 0;
      if (n != 2 || m_st != 2) m_run <= 0;
      else if (cyc) m_run <= oc ? m_run + 1 : 0;
      m_go  <= (n == 1) && (m_st != 1);
      m_st  <= n;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(hs  == exp_hs(m_st, oc), "R1 hs_permit", hs, exp_hs(m_st, oc));
    check(lso == exp_lso(m_st),    "R6 ls_off",    lso, exp_lso(m_st));
    check(ssd == exp_ssd(m_st),    "R7 ss_dis",    ssd, exp_ssd(m_st));
    check(sss == m_go,             "R8 ss_start",  sss, m_go);
    check(st  == 3'(m_st),         "R11 state",    st, m_st);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse_oc(input bit f);
    step(); cyc = 1; oc = f;
    step(); cyc = 0;
  endtask

  task automatic expect_st(input int e, input string tag);
    check(st == 3'(e), tag, st, e);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    // R10 reset state
    check(st == 0 && lso && !ssd && !hs && !sss, "R10 reset idle", st, 0);
    rst_n = 1;
    step(); expect_st(0, "R10 idle while disabled");
    en = 1; step();
    expect_st(1, "R10 enable enters soft start");
    check(sss, "R8 launch pulse on entry", sss, 1);
    // R2: flags ignored during arming
    for (int i = 1; i < ARM; i++) begin
      cyc = 1; oc = 1; uv = 1; step();
      expect_st(1, "R2 still soft start");
    end
    cyc = 0; oc = 0; uv = 0; step();
    expect_st(2, "R2 run after arming");
    // R4: clean cycle restarts count, clocks without pulse do not count
    for (int i = 0; i < RUNL - 1; i++) pulse_oc(1);
    pulse_oc(0);
    oc = 1; repeat (40) step(); oc = 0;
    for (int i = 0; i < RUNL - 1; i++) pulse_oc(1);
    expect_st(2, "R4 count restarted by clean cycle");
    // R3
    pulse_oc(1); oc = 0;
    expect_st(3, "R3 hiccup after run of pulses");
    check(!lso && !hs, "R6 low side usable before zcd", lso, 0);
    repeat (5) step();
    expect_st(3, "R6 holds until zcd");
    zcd = 1; step(); zcd = 0;
    expect_st(4, "R6 off after zcd");
    check(lso && ssd, "R7 discharge and ls off", {lso, ssd}, 3);
    for (int i = 1; i < WT; i++) begin step(); expect_st(4, "R8 off interval"); end
    step();
    expect_st(1, "R8 restart after wait");
    check(sss, "R8 restart pulse", sss, 1);
    // R9
    ot = 1; step();
    expect_st(5, "R9 thermal entry");
    repeat (4) step();
    ot = 0; step();
    expect_st(1, "R9 thermal release");
    // R5
    repeat (ARM) step();
    expect_st(2, "R5 run");
    uv = 1; step(); uv = 0;
    expect_st(3, "R5 uv hiccup");
    // R10
    en = 0; step();
    expect_st(0, "R10 disable returns idle");
    check(!ssd, "R10 discharge cleared", ssd, 0);
    en = 1;
    // Random phase
    for (int i = 0; i < 20000; i++) begin
      step();
      cyc = ($urandom_range(0, 2) == 0);
      oc  = ($urandom_range(0, 99) < 93);
      uv  = ($urandom_range(0, 399) == 0);
      zcd = ($urandom_range(0, 5) == 0);
      if (ot ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 599) == 0)) ot = ~ot;
      if (en ? ($urandom_range(0, 799) == 0) : ($urandom_range(0, 4) == 0)) en = ~en;
    end
    step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule